// File: doc/BRIEF.md
# Reloading Down-Counter Timer Channel

One countdown channel of a system timer, reached through a small register window. Software writes a start value, picks a tick source and a mode in the control word, and enables the channel. Each enabled tick from the selected source takes one off the counter. When a tick arrives while the counter is at zero, the channel raises a level interrupt. It then either reloads the start value (periodic mode) or wraps to all ones (free-running mode) and carries on counting.

The interrupt stays high until software writes any value to the acknowledge register. The tick enables come from outside as single-cycle pulses: a slow one and a fast one. The counter is 16 or 32 bits wide, set by a parameter. Register reads have no side effects and are zero-extended to the data width.

Top module: `dtimer_channel`

## Requirements
- R1: After reset the start value, the counter, the control word and the interrupt are all zero.
- R2: Word offsets within the window are fixed. 0x0 is the start value (read/write), 0x4 the counter (read), 0x8 the control word and 0xC the acknowledge register, which reads as zero. The control word reads back only bits 7, 6 and 3, with all other bits zero.
- R3: A write to offset 0x0 stores the start value and also places it in the counter in the same cycle. The next tick counts down from the new value.
- R4: When control bit 7 is set, the counter drops by one on each pulse of the selected tick. Control bit 3 = 1 selects slow_tick and bit 3 = 0 selects fast_tick. Pulses on the other input have no effect.
- R5: A selected tick while the counter is zero is an underflow. It sets irq, and irq stays high through later ticks until it is acknowledged.
- R6: With control bit 6 set (periodic mode), the counter reloads the start value on underflow and then keeps counting down.
- R7: With control bit 6 clear (free-running mode), the counter becomes all ones on underflow.
- R8: A write of any data to offset 0xC clears irq in the next cycle. If an underflow happens in the same cycle, the underflow wins and irq stays high.
- R9: While control bit 7 is clear, including after a write of zero to the control word, the counter holds its value and no new interrupt is raised.
- R10: The counter register at offset 0x4 is read-only. Writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slow_tick | input | 1 | Slow count enable pulse |
| fast_tick | input | 1 | Fast count enable pulse |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Byte offset within the channel window |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for addr, combinational |
| irq | output | 1 | Underflow interrupt, level |

## Verification
The embedded properties check four things on every cycle:
- the counter holds while the channel is disabled;
- each enabled tick decrements by exactly one;
- an underflow leads to the reload value in periodic mode and to all ones in free-running mode;
- irq rises only after an underflow and falls after an acknowledge.

Other behaviour is shown only by the bench's scenarios:
- that the tick-source select really ignores the other input;
- the register offsets and readback masks;
- that a write to the counter register does nothing;
- that the interrupt survives further ticks;
- that an underflow wins over an acknowledge in the same cycle.

// File: rtl/dtimer_channel.sv
module dtimer_channel #(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick,
  input  logic              fast_tick,
  input  logic              wr_en,
  input  logic [3:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  localparam logic [1:0] OFS_LOAD = 2'd0;
  localparam logic [1:0] OFS_CNT  = 2'd1;
  localparam logic [1:0] OFS_CTRL = 2'd2;
  localparam logic [1:0] OFS_ACK  = 2'd3;
  localparam int BIT_EN  = 7;
  localparam int BIT_PER = 6;
  localparam int BIT_SEL = 3;

  logic [CNT_W-1:0] load_q, cnt_q;
  logic en_q, per_q, sel_q, irq_q;

  logic wr_load, wr_ctrl, wr_ack, step, uflow;
  assign wr_load = wr_en && addr[3:2] == OFS_LOAD;
  assign wr_ctrl = wr_en && addr[3:2] == OFS_CTRL;
  assign wr_ack  = wr_en && addr[3:2] == OFS_ACK;
  assign step    = en_q && (sel_q ? slow_tick : fast_tick);
  assign uflow   = step && cnt_q == '0 && !wr_load;
  assign irq     = irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= '0;
      cnt_q  <= '0;
      en_q   <= 1'b0;
      per_q  <= 1'b0;
      sel_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_load) begin
        load_q <= wdata[CNT_W-1:0];
        cnt_q  <= wdata[CNT_W-1:0];
      end else if (step) begin
        if (cnt_q == '0) cnt_q <= per_q ? load_q : '1;
        else             cnt_q <= cnt_q - 1'b1;
      end
      if (wr_ctrl) begin
        en_q  <= wdata[BIT_EN];
        per_q <= wdata[BIT_PER];
        sel_q <= wdata[BIT_SEL];
      end
      if (uflow)       irq_q <= 1'b1;
      else if (wr_ack) irq_q <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr[3:2])
      OFS_LOAD: rdata[CNT_W-1:0] = load_q;
      OFS_CNT:  rdata[CNT_W-1:0] = cnt_q;
      OFS_CTRL: begin
        rdata[BIT_EN]  = en_q;
        rdata[BIT_PER] = per_q;
        rdata[BIT_SEL] = sel_q;
      end
      default:  rdata = '0;
    endcase
  end

  p_hold_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !wr_load) |=> $stable(cnt_q));

  p_dec_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt_q != '0 && !wr_load) |=> cnt_q == $past(cnt_q) - 1'b1);

  p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (uflow && per_q) |=> cnt_q == $past(load_q));

  p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (uflow && !per_q) |=> cnt_q == {CNT_W{1'b1}});

  p_irq_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(uflow));

  p_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ack && !uflow) |=> !irq_q);

  p_write_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_load |=> cnt_q == $past(wdata[CNT_W-1:0]));
endmodule

// File: tb/test_dtimer_channel.sv
module test_dtimer_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_tick = 1'b0, fast_tick = 1'b0, wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  always #2 clk = ~clk;

  dtimer_channel #(.CNT_W(32), .DATA_W(32)) i_dtimer_channel (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .fast_tick(fast_tick),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  typedef struct { bit is_irq; logic [31:0] exp; string req; } item_t;
  item_t exp_q[$];
  bit    pend = 1'b0;
  int    checks = 0, errors = 0;
  bit    done = 1'b0;

  always @(negedge clk) begin
    #1;
    if (pend && exp_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = exp_q.pop_front();
      act = it.is_irq ? {31'd0, irq} : rdata;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s actual %h expected %h", it.req, act, it.exp);
      end
    end
  end

  task automatic cyc(input bit w, input logic [3:0] a, input logic [31:0] d,
                     input bit s, input bit f);
    @(negedge clk);
    pend = 1'b0; wr_en = w; addr = a; wdata = d; slow_tick = s; fast_tick = f;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    cyc(1'b1, a, d, 1'b0, 1'b0);
  endtask

  task automatic ticks(input int n, input bit s, input bit f);
    for (int i = 0; i < n; i++) cyc(1'b0, 4'h0, '0, s, f);
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string req);
    item_t it;
    it.is_irq = 1'b0; it.exp = e; it.req = req;
    exp_q.push_back(it);
    cyc(1'b0, a, '0, 1'b0, 1'b0);
    pend = 1'b1;
  endtask

  task automatic chk_irq(input bit e, input string req);
    item_t it;
    it.is_irq = 1'b1; it.exp = {31'd0, e}; it.req = req;
    exp_q.push_back(it);
    cyc(1'b0, 4'h0, '0, 1'b0, 1'b0);
    pend = 1'b1;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(4'h0, 32'h0, "R1 load");
    rd(4'h4, 32'h0, "R1 count");
    rd(4'h8, 32'h0, "R1 ctrl");
    chk_irq(1'b0, "R1 irq");

    wr(4'h0, 32'd5);
    rd(4'h4, 32'd5, "R3 count after load");
    rd(4'h0, 32'd5, "R2 load readback");
    wr(4'h8, 32'hFFFF_FFC8);
    rd(4'h8, 32'h0000_00C8, "R2 ctrl mask");
    ticks(3, 1'b0, 1'b1);
    rd(4'h4, 32'd5, "R4 unselected fast ignored");
    ticks(2, 1'b1, 1'b0);
    rd(4'h4, 32'd3, "R4 slow decrement");
    ticks(3, 1'b1, 1'b0);
    rd(4'h4, 32'd0, "R4 reach zero");
    chk_irq(1'b0, "R5 no irq at zero");
    ticks(1, 1'b1, 1'b0);
    rd(4'h4, 32'd5, "R6 periodic reload");
    chk_irq(1'b1, "R5 irq on underflow");
    ticks(1, 1'b1, 1'b0);
    rd(4'h4, 32'd4, "R6 continue after reload");
    chk_irq(1'b1, "R5 irq held");

    wr(4'h4, 32'h77);
    rd(4'h4, 32'd4, "R10 count write ignored");
    rd(4'h0, 32'd5, "R10 load untouched");
    wr(4'hC, 32'h0);
    chk_irq(1'b0, "R8 ack clears");
    rd(4'hC, 32'h0, "R2 ack reads zero");

    wr(4'h8, 32'h80);
    wr(4'h0, 32'd1);
    ticks(2, 1'b0, 1'b1);
    rd(4'h4, 32'hFFFF_FFFF, "R7 free-run wrap");
    chk_irq(1'b1, "R7 irq on wrap");

    wr(4'h8, 32'h0);
    ticks(3, 1'b0, 1'b1);
    rd(4'h4, 32'hFFFF_FFFF, "R9 hold when stopped");
    wr(4'hC, 32'hDEAD_BEEF);
    wr(4'h0, 32'd0);
    ticks(3, 1'b0, 1'b1);
    rd(4'h4, 32'd0, "R9 hold at zero");
    chk_irq(1'b0, "R9 no irq when stopped");

    wr(4'h8, 32'h80);
    cyc(1'b1, 4'hC, 32'h1, 1'b0, 1'b1);
    chk_irq(1'b1, "R8 underflow beats ack");
    rd(4'h4, 32'hFFFF_FFFF, "R7 wrap from zero");

    cyc(1'b0, 4'h0, '0, 1'b0, 1'b0);
    cyc(1'b0, 4'h0, '0, 1'b0, 1'b0);
    if (exp_q.size() != 0) begin
      errors++; checks++;
      $display("FAIL scoreboard actual %0d left expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule